// File: doc/BRIEF.md
# Selectable-Edge Input Data Latch

This block keeps the input word that a host reads, so the host never samples the live input lines directly. A two-bit source select picks the event that loads the word. Either the flag from the peripheral moves from busy to ready, or it moves from ready to busy, or the host issues a read strobe. In the two flag modes the word changes only when the flag changes. A host that reads again with no flag activity therefore gets the same word back, whatever the lines do in the meantime.

The raw lines pass through a two-stage register before capture. This matches the two-stage synchroniser that already sits in front of the flag input, so a captured word corresponds to the lines as they stood when the flag moved at the pins. A per-bit inversion mask sets the logic sense of every line at the moment of capture. In packing mode two consecutive load events each contribute the low byte of the lines. The first byte goes into the low half of the word. The word and its valid flag are presented only after the second byte arrives.

Top module: `strobe_capture_reg`

## Requirements
- R1: While reset is asserted and after its release, before any load, `rd_data` is all zeros and `word_vld` is 0.
- R2: With `src_sel` = 0, the word loads on the clock edge at which `flag_ready` is first sampled as 1 after having been 0 (busy-to-ready). It does not load on a 1-to-0 change or on a read strobe.
- R3: With `src_sel` = 1, the word loads on the clock edge at which `flag_ready` is first sampled as 0 after having been 1 (ready-to-busy). It does not load on a 0-to-1 change or on a read strobe.
- R4: With `src_sel` = 2, the word loads on the clock edge that samples `rd_stb` high, and the new word is on `rd_data` in the following cycle. Changes of `flag_ready` have no effect in this mode.
- R5: With `src_sel` = 0 or 1, read strobes leave `rd_data` unchanged. Repeated reads with no flag change return the same word even when the input lines change.
- R6: With `src_sel` = 3 (reserved), no event loads the word.
- R7: The stored value is the sampled lines XOR `pol_inv` as `pol_inv` stands at the load edge. A later change of `pol_inv` does not alter a word already stored.
- R8: A load takes the lines as sampled two rising clock edges before the load edge. A line change made at least two edges ahead of the flag change is captured. A change made one edge ahead, or together with the flag change, is not captured.
- R9: With `pack8` = 1, a load of the first byte of a pair stores bits [7:0] of the sense-corrected lines, leaves `rd_data` unchanged and clears `word_vld`. The second load sets `rd_data` to {second byte, first byte} and sets `word_vld` to 1.
- R10: With `pack8` = 0, every load replaces the whole 16-bit word and sets `word_vld` to 1.
- R11: Any clock with `pack8` = 0 discards a pending first byte. The next load in packing mode starts a new pair.
- R12: A read strobe and a flag change in the same cycle produce exactly one load, taken from the event the selected source names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 16 | Raw input data lines |
| flag_ready | input | 1 | Synchronised peripheral flag, 1 = ready, 0 = busy |
| rd_stb | input | 1 | Host read strobe, one cycle per read |
| src_sel | input | 2 | Load source: 0 busy-to-ready, 1 ready-to-busy, 2 host read, 3 none |
| pol_inv | input | 16 | Per-line inversion mask applied at capture |
| pack8 | input | 1 | 1 = assemble two bytes into one word |
| rd_data | output | 16 | Stored input word |
| word_vld | output | 1 | A complete word is held in `rd_data` |

## Verification
A host read strobe and a flag change can arrive in the same cycle, and only the selected source may load the word. The bench provokes this in directed cases under each source and in random stimulus, where the strobe and the flag toggle are drawn independently. It judges the result by comparing `rd_data` and `word_vld` one cycle later against a model that applies exactly one load, or none, for the chosen source. In packing mode the same collision must advance the byte phase only once, which the next event of the pair then exposes.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef enum logic [1:0] {
    SRC_RISE = 2'd0,
    SRC_FALL = 2'd1,
    SRC_READ = 2'd2,
    SRC_NONE = 2'd3
  } src_t;
endpackage

// File: rtl/scl_line_pipe.sv
module scl_line_pipe #(
  parameter int DW     = 16,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) stg[0] <= din;
    end else begin : g_tail
      always_ff @(posedge clk) stg[g] <= stg[g-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/scl_flag_edge.sv
module scl_flag_edge (
  input  logic clk,
  input  logic flag_ready,
  output logic rise_evt,
  output logic fall_evt
);
  logic flag_q;

  // Tracks the flag during reset too, so release never shows a false edge.
  always_ff @(posedge clk) flag_q <= flag_ready;

  assign rise_evt = flag_ready & ~flag_q;
  assign fall_evt = ~flag_ready & flag_q;
endmodule

// File: rtl/scl_word_store.sv
module scl_word_store #(
  parameter int DW = 16,
  localparam int BW = DW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_evt,
  input  logic          pack8,
  input  logic [DW-1:0] cap_word,
  output logic [DW-1:0] rd_data,
  output logic          word_vld,
  output logic          half_phase
);
  logic [BW-1:0] hold_byte;

  function automatic logic [DW-1:0] join_pair(input logic [BW-1:0] hi,
                                              input logic [BW-1:0] lo);
    return {hi, lo};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data    <= '0;
      word_vld   <= 1'b0;
      half_phase <= 1'b0;
      hold_byte  <= '0;
    end else if (load_evt) begin
      if (pack8) begin
        if (!half_phase) begin
          hold_byte  <= cap_word[BW-1:0];
          word_vld   <= 1'b0;
          half_phase <= 1'b1;
        end else begin
          rd_data    <= join_pair(cap_word[BW-1:0], hold_byte);
          word_vld   <= 1'b1;
          half_phase <= 1'b0;
        end
      end else begin
        rd_data    <= cap_word;
        word_vld   <= 1'b1;
        half_phase <= 1'b0;
      end
    end else if (!pack8) begin
      half_phase <= 1'b0;
    end
  end
endmodule

// File: rtl/strobe_capture_reg.sv
module strobe_capture_reg
  import scl_pkg::*;
#(
  parameter int DW     = 16,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          flag_ready,
  input  logic          rd_stb,
  input  logic [1:0]    src_sel,
  input  logic [DW-1:0] pol_inv,
  input  logic          pack8,
  output logic [DW-1:0] rd_data,
  output logic          word_vld
);
  logic [DW-1:0] din_q;
  logic          rise_evt;
  logic          fall_evt;
  logic          load_evt;
  logic          half_phase;
  logic [DW-1:0] cap_word;
  src_t          sel;

  function automatic logic pick_load(input src_t s, input logic r,
                                     input logic f, input logic rd);
    case (s)
      SRC_RISE: return r;
      SRC_FALL: return f;
      SRC_READ: return rd;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic [DW-1:0] apply_sense(input logic [DW-1:0] d,
                                                input logic [DW-1:0] m);
    return d ^ m;
  endfunction

  scl_line_pipe #(.DW(DW), .STAGES(STAGES)) i_pipe (
    .clk (clk),
    .din (din),
    .dout(din_q)
  );

  scl_flag_edge i_edge (
    .clk       (clk),
    .flag_ready(flag_ready),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt)
  );

  assign sel      = src_t'(src_sel);
  assign load_evt = pick_load(sel, rise_evt, fall_evt, rd_stb);
  assign cap_word = apply_sense(din_q, pol_inv);

  scl_word_store #(.DW(DW)) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_evt  (load_evt),
    .pack8     (pack8),
    .cap_word  (cap_word),
    .rd_data   (rd_data),
    .word_vld  (word_vld),
    .half_phase(half_phase)
  );
endmodule

// File: rtl/scl_checker.sv
module scl_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] din,
  input logic [DW-1:0] pol_inv,
  input logic          rd_stb,
  input logic [1:0]    src_sel,
  input logic          pack8,
  input logic [DW-1:0] rd_data,
  input logic          word_vld,
  input logic          load_evt,
  input logic          half_phase
);
  AST_NO_LOAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(rd_data) && $stable(word_vld)); // R5

  AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd3) |-> !load_evt); // R6

  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd2 && rd_stb && !pack8) |=>
      (rd_data == ($past(din, 3) ^ $past(pol_inv))) && word_vld); // R4

  AST_READ_MODE_FLAG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd2 && !rd_stb) |=> $stable(rd_data)); // R4

  AST_FIRST_BYTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pack8 && load_evt && !half_phase) |=> $stable(rd_data) && !word_vld); // R9

  AST_SECOND_BYTE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (pack8 && load_evt && half_phase) |=> word_vld && !half_phase); // R9

  AST_WIDE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!pack8 && load_evt) |=> word_vld); // R10

  AST_PHASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !pack8 |=> !half_phase); // R11
endmodule

bind strobe_capture_reg scl_checker #(.DW(DW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .din       (din),
  .pol_inv   (pol_inv),
  .rd_stb    (rd_stb),
  .src_sel   (src_sel),
  .pack8     (pack8),
  .rd_data   (rd_data),
  .word_vld  (word_vld),
  .load_evt  (load_evt),
  .half_phase(half_phase)
);

// File: tb/test_strobe_capture_reg.sv
module test_strobe_capture_reg;
  localparam int DW = 16;
  localparam int BW = DW / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic          flag = 1'b1;
  logic          rd_stb = 1'b0;
  logic [1:0]    src = 2'd0;
  logic [DW-1:0] pol = '0;
  logic          pk = 1'b0;
  logic [DW-1:0] rd_data;
  logic          word_vld;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_data = '0;
  logic          m_vld = 1'b0;
  logic          m_phase = 1'b0;
  logic [BW-1:0] m_hold = '0;

  always #5 clk = ~clk;

  strobe_capture_reg #(.DW(DW)) i_strobe_capture_reg (
    .clk(clk), .rst_n(rst_n), .din(din), .flag_ready(flag), .rd_stb(rd_stb),
    .src_sel(src), .pol_inv(pol), .pack8(pk), .rd_data(rd_data), .word_vld(word_vld)
  );

  function automatic logic [DW-1:0] two_bytes(input logic [BW-1:0] second,
                                              input logic [BW-1:0] first);
    logic [DW-1:0] w;
    w = DW'(second);
    w = (w << BW) | DW'(first);
    return w;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_load(input logic [DW-1:0] v);
    if (pk) begin
      if (!m_phase) begin
        m_hold  = v[BW-1:0];
        m_vld   = 1'b0;
        m_phase = 1'b1;
      end else begin
        m_data  = two_bytes(v[BW-1:0], m_hold);
        m_vld   = 1'b1;
        m_phase = 1'b0;
      end
    end else begin
      m_data  = v;
      m_vld   = 1'b1;
      m_phase = 1'b0;
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] s, input logic [DW-1:0] p, input logic k);
    src = s; pol = p; pk = k;
    if (!k) m_phase = 1'b0;
  endtask

  // Called at a negedge. lines: value the design should capture on a load.
  task automatic ev(input logic tog, input logic rd, input logic [DW-1:0] lines,
                    input string req);
    logic nf;
    logic ld;
    nf = tog ? ~flag : flag;
    flag = nf;
    rd_stb = rd;
    ld = (src == 2'd0 && tog && nf) || (src == 2'd1 && tog && !nf) ||
         (src == 2'd2 && rd);
    step(1);
    rd_stb = 1'b0;
    if (ld) model_load(lines ^ pol);
    check(req, "word", rd_data, m_data);
    check(req, "valid", DW'(word_vld), DW'(m_vld));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    step(4);
    check("R1", "word in reset", rd_data, '0);
    check("R1", "valid in reset", DW'(word_vld), '0);
    rst_n = 1'b1;
    step(2);
    check("R1", "word after reset", rd_data, '0);
    check("R1", "valid after reset", DW'(word_vld), '0);

    // R2: busy-to-ready source
    set_mode(2'd0, '0, 1'b0);
    din = 16'hA5C3; step(3);
    ev(1'b1, 1'b0, din, "R2");      // ready->busy: no load
    ev(1'b1, 1'b0, din, "R2");      // busy->ready: load
    ev(1'b0, 1'b1, din, "R2");      // read only: no load

    // R3: ready-to-busy source
    set_mode(2'd1, '0, 1'b0);
    din = 16'h3C5A; step(3);
    ev(1'b1, 1'b0, din, "R3");      // ready->busy: load
    din = 16'h1111; step(3);
    ev(1'b1, 1'b0, din, "R3");      // busy->ready: no load

    // R5: repeated reads without flag change
    for (int i = 0; i < 4; i++) begin
      din = DW'($urandom); step(3);
      ev(1'b0, 1'b1, din, "R5");
    end
    check("R5", "word held over reads", rd_data, 16'h3C5A);

    // R4: host read source, flag ignored
    set_mode(2'd2, '0, 1'b0);
    din = 16'h0F0F; step(3);
    ev(1'b1, 1'b0, din, "R4");
    ev(1'b0, 1'b1, din, "R4");
    check("R4", "read capture", rd_data, 16'h0F0F);

    // R6: reserved select
    set_mode(2'd3, '0, 1'b0);
    din = 16'hDEAD; step(3);
    ev(1'b1, 1'b0, din, "R6");
    ev(1'b1, 1'b1, din, "R6");
    check("R6", "reserved no load", rd_data, 16'h0F0F);

    // R7: sense applied at capture only
    set_mode(2'd2, 16'hFF00, 1'b0);
    din = 16'h1234; step(3);
    ev(1'b0, 1'b1, din, "R7");
    check("R7", "inverted capture", rd_data, 16'hED34);
    pol = 16'h00FF; step(3);
    check("R7", "later mask change", rd_data, 16'hED34);

    // R8: alignment of lines to the flag edge
    set_mode(2'd0, '0, 1'b0);
    din = 16'h4444; step(3);
    if (flag) ev(1'b1, 1'b0, din, "R8");
    step(2);
    din = 16'h5555;
    ev(1'b1, 1'b0, 16'h4444, "R8"); // changed together: old captured
    check("R8", "same-cycle change", rd_data, 16'h4444);
    ev(1'b1, 1'b0, din, "R8");      // back to busy
    step(3);
    din = 16'h6666; step(1);
    ev(1'b1, 1'b0, 16'h5555, "R8"); // one edge ahead: old captured
    check("R8", "one-edge lead", rd_data, 16'h5555);
    ev(1'b1, 1'b0, din, "R8");
    step(3);
    din = 16'h7777; step(2);
    ev(1'b1, 1'b0, 16'h7777, "R8"); // two edges ahead: new captured
    check("R8", "two-edge lead", rd_data, 16'h7777);

    // R9: byte pair assembly
    set_mode(2'd2, '0, 1'b1);
    din = 16'hEE11; step(3);
    ev(1'b0, 1'b1, din, "R9");
    check("R9", "first byte hides word", rd_data, 16'h7777);
    check("R9", "first byte clears valid", DW'(word_vld), '0);
    din = 16'hDD22; step(3);
    ev(1'b0, 1'b1, din, "R9");
    check("R9", "pair word", rd_data, 16'h2211);

    // R11: leaving packing discards the pending byte
    din = 16'h0033; step(3);
    ev(1'b0, 1'b1, din, "R11");
    set_mode(2'd2, '0, 1'b0); step(2);
    set_mode(2'd2, '0, 1'b1);
    din = 16'h0044; step(3);
    ev(1'b0, 1'b1, din, "R11");
    din = 16'h0055; step(3);
    ev(1'b0, 1'b1, din, "R11");
    check("R11", "fresh pair", rd_data, 16'h5544);

    // R10 and R12: full word and collisions
    set_mode(2'd2, '0, 1'b0);
    din = 16'h9876; step(3);
    ev(1'b1, 1'b1, din, "R12");
    check("R10", "full word valid", DW'(word_vld), 16'h0001);
    set_mode(2'd0, '0, 1'b1);
    din = 16'h00AB; step(3);
    if (flag) ev(1'b1, 1'b0, din, "R12");
    ev(1'b1, 1'b1, din, "R12");
    din = 16'h00CD; step(3);
    ev(1'b1, 1'b0, din, "R12");
    ev(1'b1, 1'b1, din, "R12");
    check("R12", "one byte per collision", rd_data, 16'hCDAB);

    // Random stimulus
    for (int i = 0; i < 500; i++) begin
      logic [1:0] k;
      string tag;
      if (($urandom % 4) == 0)
        set_mode(2'($urandom), DW'($urandom), 1'($urandom));
      din = DW'($urandom);
      step(3);
      k = 2'($urandom);
      case (src)
        2'd0: tag = "R2";
        2'd1: tag = "R3";
        2'd2: tag = pk ? "R9" : "R4";
        default: tag = "R6";
      endcase
      ev(k[0], k[1], din, tag);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule